// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Ratio Controller

This block holds one 16-bit ratio word that sets the divide ratio of six clock domains fed from a common parent clock: peripheral, lcd, cpu, dsp, bus and dsp-mmu. Each domain has a 2-bit exponent `e` and runs at the parent rate divided by `2^e`, so the ratio is 1, 2, 4 or 8. The block does not switch clocks. Each domain instead gets a clock-enable that is high on one parent cycle in every `2^e`.

Software writes a raw word through a single write strobe. On the way into storage, a correction stage adjusts the fields so that the rules between domains always hold. The dsp-mmu domain runs at the dsp rate or at half of it. The bus domain is never faster than cpu or dsp-mmu. The lcd and peripheral domains are never faster than the bus. The readback port always shows the corrected word.

A free-running counter drives all the enables. A newly stored word takes effect on the enables only when that counter wraps to zero, which keeps every domain's pulses phase-aligned.

Top module: `div_ratio_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0 and all six bits of `dom_en` are high (divide by 1 everywhere).
- R2: If the written dsp-mmu exponent (bits [11:10]) is below the dsp exponent (bits [7:6]), it is stored equal to the dsp exponent.
- R3: If the written dsp-mmu exponent exceeds the dsp exponent plus one, it is stored as the dsp exponent plus one. With dsp at 3, a dsp-mmu value of 3 is kept.
- R4: The bus exponent (bits [9:8]) is raised to at least the cpu exponent (bits [5:4]) and to at least the already corrected dsp-mmu exponent.
- R5: The lcd exponent (bits [3:2]) and the peripheral exponent (bits [1:0]) are raised to at least the corrected bus exponent.
- R6: The cpu and dsp exponents and bits [15:12] are stored exactly as written.
- R7: `dom_en[d]` belongs to the field at bits [2d+1:2d]: 0 peripheral, 1 lcd, 2 cpu, 3 dsp, 4 bus, 5 dsp-mmu. It is high exactly when the low `e` bits of the 3-bit phase counter are zero, so it is always high for `e`=0.
- R8: `rd_data` shows the corrected word from the clock edge that samples `wr_en`. It holds its value while `wr_en` is low.
- R9: The stored word is applied to `dom_en` only at the edge where the phase counter wraps from 7 to 0. The last word stored before that edge is the one applied.
- R10: The phase counter advances by one every cycle from 0 after reset, and every bit of `dom_en` is high whenever the counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the ratio word |
| wr_data | input | 16 | Raw ratio word to be corrected and stored |
| rd_data | output | 16 | Corrected stored ratio word |
| dom_en | output | 6 | Per-domain clock-enable pulses |

## Verification
Some rules are checked by assertions on every cycle:
- the ordering rules between fields of the stored word;
- the stored word holding when no write is made;
- the applied word changing only at the counter wrap;
- the counter stepping by one;
- an exponent of zero giving a constant enable.

Other behaviour can only be shown by the bench's scenarios, each of which writes a specific raw word:
- that the correction order is right, for example that a bus exponent is raised by a dsp-mmu value that was itself raised first;
- that the dsp exponent of 3 edge case is handled;
- that the high bits pass through;
- that two writes inside one counter period leave only the second one applied.

The bench models the counter, the stored word and the applied word, and compares every enable bit on every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int EXP_W   = 2;
   localparam int CFG_W   = 16;
   localparam int NUM_DOM = 6;
   localparam int CNT_W   = (1 << EXP_W) - 1;
   // domain indices; field d lives at bits [d*EXP_W +: EXP_W]
   localparam int D_PER = 0;
   localparam int D_LCD = 1;
   localparam int D_CPU = 2;
   localparam int D_DSP = 3;
   localparam int D_BUS = 4;
   localparam int D_MMU = 5;
endpackage

// File: rtl/ratio_sanitizer.sv
module ratio_sanitizer
   import clkdiv_pkg::*;
#(
   parameter int P_EXP_W   = EXP_W,
   parameter int P_CFG_W   = CFG_W,
   parameter int P_NUM_DOM = NUM_DOM
)(
   input  logic [P_CFG_W-1:0] raw_word,
   output logic [P_CFG_W-1:0] clean_word
);
   localparam int FLD_W = P_NUM_DOM * P_EXP_W;
   localparam int WW    = P_EXP_W + 1;

   generate
      if (P_NUM_DOM != 6) begin : g_bad_dom
         $error("ratio_sanitizer: rule set needs exactly six domains");
      end
      if (P_CFG_W < FLD_W) begin : g_bad_w
         $error("ratio_sanitizer: word too narrow for fields");
      end
   endgenerate

   logic [P_EXP_W-1:0] f_in  [P_NUM_DOM];
   logic [P_EXP_W-1:0] f_out [P_NUM_DOM];

   genvar d;
   generate
      for (d = 0; d < P_NUM_DOM; d++) begin : g_fld
         assign f_in[d] = raw_word[d*P_EXP_W +: P_EXP_W];
         assign clean_word[d*P_EXP_W +: P_EXP_W] = f_out[d];
      end
      if (P_CFG_W > FLD_W) begin : g_keep
         assign clean_word[P_CFG_W-1:FLD_W] = raw_word[P_CFG_W-1:FLD_W];
      end
   endgenerate

   // widened by one bit so dsp+1 cannot wrap
   logic [WW-1:0] dsp_w, cpu_w, mmu_w, bus_w, lcd_w, per_w, lim_w;

   always_comb begin
      dsp_w = {1'b0, f_in[D_DSP]};
      cpu_w = {1'b0, f_in[D_CPU]};
      mmu_w = {1'b0, f_in[D_MMU]};
      bus_w = {1'b0, f_in[D_BUS]};
      lcd_w = {1'b0, f_in[D_LCD]};
      per_w = {1'b0, f_in[D_PER]};
      lim_w = dsp_w + WW'(1);
      // stage 1: dsp-mmu within [dsp, dsp+1]
      if (mmu_w < dsp_w) mmu_w = dsp_w;
      if (mmu_w > lim_w) mmu_w = lim_w;
      // stage 2: bus no faster than cpu or dsp-mmu
      if (bus_w < cpu_w) bus_w = cpu_w;
      if (bus_w < mmu_w) bus_w = mmu_w;
      // stage 3: lcd and peripheral no faster than bus
      if (lcd_w < bus_w) lcd_w = bus_w;
      if (per_w < bus_w) per_w = bus_w;
      f_out[D_DSP] = dsp_w[P_EXP_W-1:0];
      f_out[D_CPU] = cpu_w[P_EXP_W-1:0];
      f_out[D_MMU] = mmu_w[P_EXP_W-1:0];
      f_out[D_BUS] = bus_w[P_EXP_W-1:0];
      f_out[D_LCD] = lcd_w[P_EXP_W-1:0];
      f_out[D_PER] = per_w[P_EXP_W-1:0];
   end

   // R6: pass-through fields equal the raw fields
   always_comb begin
      a_r6_passthru: assert (f_out[D_CPU] == f_in[D_CPU] && f_out[D_DSP] == f_in[D_DSP]);
   end
endmodule

// File: rtl/phase_counter.sv
module phase_counter
   import clkdiv_pkg::*;
#(
   parameter int P_CNT_W = CNT_W
)(
   input  logic               clk,
   input  logic               rst_n,
   output logic [P_CNT_W-1:0] cnt,
   output logic               wrap
);
   generate
      if (P_CNT_W < 1) begin : g_bad
         $error("phase_counter: width must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + P_CNT_W'(1);
   end

   assign wrap = (cnt == {P_CNT_W{1'b1}});

   a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt == P_CNT_W'($past(cnt) + P_CNT_W'(1)));
endmodule

// File: rtl/ratio_cfg_store.sv
module ratio_cfg_store
   import clkdiv_pkg::*;
#(
   parameter int P_EXP_W = EXP_W,
   parameter int P_CFG_W = CFG_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [P_CFG_W-1:0] clean_in,
   input  logic               wrap,
   output logic [P_CFG_W-1:0] stored,
   output logic [P_CFG_W-1:0] active
);
   localparam int WW = P_EXP_W + 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored <= '0;
         active <= '0;
      end else begin
         if (wr_en) stored <= clean_in;
         if (wrap)  active <= stored;
      end
   end

   logic [WW-1:0] s_dsp, s_mmu, s_bus, s_cpu, s_lcd, s_per;
   assign s_dsp = {1'b0, stored[D_DSP*P_EXP_W +: P_EXP_W]};
   assign s_mmu = {1'b0, stored[D_MMU*P_EXP_W +: P_EXP_W]};
   assign s_bus = {1'b0, stored[D_BUS*P_EXP_W +: P_EXP_W]};
   assign s_cpu = {1'b0, stored[D_CPU*P_EXP_W +: P_EXP_W]};
   assign s_lcd = {1'b0, stored[D_LCD*P_EXP_W +: P_EXP_W]};
   assign s_per = {1'b0, stored[D_PER*P_EXP_W +: P_EXP_W]};

   a_r2_mmu_not_below_dsp: assert property (@(posedge clk) disable iff (!rst_n)
      s_mmu >= s_dsp);
   a_r3_mmu_within_half: assert property (@(posedge clk) disable iff (!rst_n)
      s_mmu <= s_dsp + WW'(1));
   a_r4_bus_slowest_master: assert property (@(posedge clk) disable iff (!rst_n)
      s_bus >= s_cpu && s_bus >= s_mmu);
   a_r5_periph_below_bus: assert property (@(posedge clk) disable iff (!rst_n)
      s_lcd >= s_bus && s_per >= s_bus);
   a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(stored));
   a_r9_apply_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(active));
endmodule

// File: rtl/domain_enable_gen.sv
module domain_enable_gen
   import clkdiv_pkg::*;
#(
   parameter int P_EXP_W   = EXP_W,
   parameter int P_CFG_W   = CFG_W,
   parameter int P_NUM_DOM = NUM_DOM,
   parameter int P_CNT_W   = CNT_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [P_CNT_W-1:0]   cnt,
   input  logic [P_CFG_W-1:0]   active,
   output logic [P_NUM_DOM-1:0] dom_en
);
   generate
      if (P_CNT_W != (1 << P_EXP_W) - 1) begin : g_bad
         $error("domain_enable_gen: counter width must match exponent range");
      end
   endgenerate

   genvar d;
   generate
      for (d = 0; d < P_NUM_DOM; d++) begin : g_dom
         logic [P_EXP_W-1:0] e;
         logic [P_CNT_W-1:0] mask;
         assign e = active[d*P_EXP_W +: P_EXP_W];
         always_comb begin
            mask = '0;
            for (int b = 0; b < P_CNT_W; b++) begin
               if (b < int'(e)) mask[b] = 1'b1;
            end
         end
         assign dom_en[d] = ((cnt & mask) == '0);

         a_r7_zero_exp_high: assert property (@(posedge clk) disable iff (!rst_n)
            (e == '0) |-> dom_en[d]);
      end
   endgenerate

   a_r10_aligned_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> (&dom_en));
endmodule

// File: rtl/div_ratio_ctrl.sv
module div_ratio_ctrl
   import clkdiv_pkg::*;
#(
   parameter int P_EXP_W   = EXP_W,
   parameter int P_CFG_W   = CFG_W,
   parameter int P_NUM_DOM = NUM_DOM
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [P_CFG_W-1:0]   wr_data,
   output logic [P_CFG_W-1:0]   rd_data,
   output logic [P_NUM_DOM-1:0] dom_en
);
   localparam int L_CNT_W = (1 << P_EXP_W) - 1;

   logic [P_CFG_W-1:0] clean_word;
   logic [P_CFG_W-1:0] stored;
   logic [P_CFG_W-1:0] active;
   logic [L_CNT_W-1:0] cnt;
   logic               wrap;

   ratio_sanitizer #(.P_EXP_W(P_EXP_W), .P_CFG_W(P_CFG_W), .P_NUM_DOM(P_NUM_DOM)) u_san (
      .raw_word   (wr_data),
      .clean_word (clean_word)
   );

   phase_counter #(.P_CNT_W(L_CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   ratio_cfg_store #(.P_EXP_W(P_EXP_W), .P_CFG_W(P_CFG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .clean_in (clean_word),
      .wrap     (wrap),
      .stored   (stored),
      .active   (active)
   );

   domain_enable_gen #(.P_EXP_W(P_EXP_W), .P_CFG_W(P_CFG_W), .P_NUM_DOM(P_NUM_DOM),
                       .P_CNT_W(L_CNT_W)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .active (active),
      .dom_en (dom_en)
   );

   assign rd_data = stored;

   a_r8_readback_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(clean_word));
endmodule

// File: tb/div_ratio_ctrl_test.sv
module div_ratio_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [5:0]  dom_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   // model state
   int          m_cnt = 0;
   logic [15:0] m_store = '0;
   logic [15:0] m_act = '0;
   logic [15:0] last_exp = '0;

   div_ratio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .dom_en(dom_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] ref_fix(input logic [15:0] w);
      int p = w[1:0];
      int l = w[3:2];
      int c = w[5:4];
      int d = w[7:6];
      int b = w[9:8];
      int m = w[11:10];
      if (m < d) m = d;
      if (m > d + 1) m = d + 1;
      if (b < c) b = c;
      if (b < m) b = m;
      if (l < b) l = b;
      if (p < b) p = b;
      return {w[15:12], 2'(m), 2'(b), 2'(d), 2'(c), 2'(l), 2'(p)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one write, expected corrected word pushed to scoreboard
   task automatic drive_write(input logic [15:0] raw, input string tag);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = raw;
      exp_q.push_back(ref_fix(raw));
      tag_q.push_back(tag);
      last_exp = ref_fix(raw);
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 16'hFFFF;   // idle garbage on data must not matter
   endtask

   // monitor: model update plus readback and enable comparison
   always @(posedge clk) begin
      logic       w;
      logic [15:0] d;
      logic       r;
      w = wr_en; d = wr_data; r = rst_n;
      #1;
      if (!r) begin
         m_cnt = 0; m_store = '0; m_act = '0;
      end else begin
         if (m_cnt == 7) m_act = m_store;
         if (w) m_store = ref_fix(d);
         m_cnt = (m_cnt + 1) % 8;
         if (w && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " R8 readback"}, {16'h0, rd_data}, {16'h0, e});
         end
         for (int k = 0; k < 6; k++) begin
            int ex;
            logic want;
            ex = int'(m_act[2*k +: 2]);
            want = ((m_cnt & ((1 << ex) - 1)) == 0);
            check($sformatf("R7/R9/R10 dom_en[%0d] cnt=%0d", k, m_cnt),
                  {31'h0, dom_en[k]}, {31'h0, want});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset rd_data", {16'h0, rd_data}, 32'h0);
      check("R1 reset dom_en", {26'h0, dom_en}, 32'h3F);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2 + R4 order + R5: dsp=2 lifts mmu, which lifts bus, which lifts lcd/per -> AA8A
      drive_write(16'hA080, "R2 R4 R5");
      check("R2 literal", {16'h0, rd_data}, 32'hAA8A);
      repeat (20) @(negedge clk);
      // R8: held while wr_en low and wr_data toggles
      check("R8 hold", {16'h0, rd_data}, {16'h0, last_exp});

      // R3: dsp=0 mmu=3 -> mmu clamped to 1
      drive_write(16'h0C00, "R3 clamp");
      check("R3 mmu field", {30'h0, rd_data[11:10]}, 32'h1);
      repeat (17) @(negedge clk);

      // R3 edge: dsp=3 mmu=3 kept
      drive_write(16'h0FC0, "R3 dsp3");
      check("R3 dsp3 mmu field", {30'h0, rd_data[11:10]}, 32'h3);
      repeat (19) @(negedge clk);

      // R4: cpu=3 lifts bus
      drive_write(16'h0030, "R4 cpu");
      check("R4 bus field", {30'h0, rd_data[9:8]}, 32'h3);
      repeat (18) @(negedge clk);

      // R5: bus=3 lifts lcd=1 and per=0
      drive_write(16'h0304, "R5");
      check("R5 lcd per", {28'h0, rd_data[3:0]}, 32'hF);
      repeat (21) @(negedge clk);

      // R6: cpu/dsp/high bits unchanged
      drive_write(16'hF0B0, "R6");
      check("R6 high bits", {28'h0, rd_data[15:12]}, 32'hF);
      check("R6 cpu dsp", {28'h0, rd_data[7:4]}, 32'hB);
      repeat (20) @(negedge clk);

      // R9: two writes within one counter period; only the second is applied
      drive_write(16'h0155, "R9 first");
      drive_write(16'h0000, "R9 second");
      repeat (24) @(negedge clk);
      drive_write(16'h0015, "R9 mid");
      repeat (3) @(negedge clk);
      drive_write(16'h0AAA, "R9 late");
      repeat (30) @(negedge clk);

      // R1 again: reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset rd_data", {16'h0, rd_data}, 32'h0);
      check("R1 re-reset dom_en", {26'h0, dom_en}, 32'h3F);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule